// File: doc/BRIEF.md
# Free-running timer with prioritized interrupt vector

This block is a free-running up-counter with two compare channels and an overflow event. Each of the three events latches its own pending flag. A read-only vector register reports the highest-priority pending source that is enabled, as a small even code. Interrupt service code reads the vector once and dispatches on the value it gets. That read also acknowledges the source it reported. Any source of lower priority stays pending and shows up on the next read.

Two clock-enable inputs, a slow one and a fast one, can drive the count. A control bit picks which one advances it. A two-bit run field stops the counter when it is zero. Software uses a simple register bus to reach five registers: control, count, two compare values and the vector. Reads are combinational in the same cycle and writes take effect at the next clock edge. The register bus and the interrupt line carry no data stream, so they are plain signals with no handshake and no back-pressure.

Register addresses: 0 control, 1 count, 2 compare one, 3 compare two, 4 vector. Control fields: bits [1:0] run field, bit 2 tick select, bit 3 overflow enable, bit 4 compare-one enable, bit 5 compare-two enable.

Top module: `vec_timer`

## Requirements
- R1: After reset the control, count, compare-one, compare-two and vector registers all read 0, and `irq` is low.
- R2: When the run field (control bits [1:0]) is 0, the count holds its value whatever the tick inputs do.
- R3: When the run field is nonzero, the count advances by one at each clock edge where the selected tick is high. Control bit 2 = 0 selects `tick_slow` and bit 2 = 1 selects `tick_fast`. The tick that is not selected has no effect.
- R4: When the count advances from 0xFFFF it becomes 0, and the overflow flag is set at that same edge.
- R5: A compare flag is set at the edge where an advance makes the count equal to that channel's compare register. Loading that value through a count write sets no flag.
- R6: A write to address 1 loads the count at the next edge and takes precedence over a tick in the same cycle.
- R7: The vector reads 2 for compare one, 4 for compare two, 10 for overflow and 0 when nothing is pending. Priority runs compare one, then compare two, then overflow. A flag counts only while its enable (control bit 4, 5 or 3) is set.
- R8: A read of the vector clears only the flag it reported, at the edge that ends the read cycle. Lower-priority flags stay pending.
- R9: `irq` is high exactly when the vector would read nonzero.
- R10: A flag whose enable is clear still latches. It appears in the vector and on `irq` as soon as its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_slow | input | 1 | Slow count enable (tick select 0) |
| tick_fast | input | 1 | Fast count enable (tick select 1) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Read data is valid in the same cycle as the request. Register writes, count advances and the flags they raise all appear one edge after the cycle that caused them. A vector-read acknowledge is also visible one cycle later. The bench therefore drives every input just after a falling edge and samples outputs one nanosecond later. It issues a new access or tick only after at least one rising edge has passed, so each expected value is read in the first cycle where it must hold. Sequences that stack several flags are read back one vector access at a time to check the order.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int NSRC = 3;
  localparam int NCMP = 2;
  localparam int AW   = 3;
  localparam int CTRL_W = 6;

  // source index doubles as priority rank: lower index wins
  localparam int SRC_CMP1 = 0;
  localparam int SRC_CMP2 = 1;
  localparam int SRC_OVF  = 2;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_COUNT = 3'd1;
  localparam logic [AW-1:0] A_CMP1  = 3'd2;
  localparam logic [AW-1:0] A_CMP2  = 3'd3;
  localparam logic [AW-1:0] A_VEC   = 3'd4;

  localparam int CB_RUN_LO = 0;
  localparam int CB_RUN_HI = 1;
  localparam int CB_TSEL   = 2;
  localparam int CB_IE_OVF = 3;
  localparam int CB_IE_C1  = 4;
  localparam int CB_IE_C2  = 5;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      SRC_CMP1: src_code = 4'd2;
      SRC_CMP2: src_code = 4'd4;
      SRC_OVF:  src_code = 4'd10;
      default:  src_code = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/vt_counter.sv
module vt_counter
  import vt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     tsel,
  input  logic                     tick_slow,
  input  logic                     tick_fast,
  input  logic                     load,
  input  logic [CW-1:0]            load_val,
  input  logic [NCMP-1:0][CW-1:0]  cmp_val,
  output logic [CW-1:0]            count,
  output logic                     step,
  output logic [NSRC-1:0]          ev
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          tick;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign tick    = tsel ? tick_fast : tick_slow;
  assign step    = run & tick & ~load;
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (step)  cnt_q <= cnt_inc;
  end

  for (genvar j = 0; j < NCMP; j++) begin : g_cmp
    assign ev[j] = step & (cnt_inc == cmp_val[j]);
  end
  assign ev[SRC_OVF] = step & (cnt_q == CMAX);

  assign count = cnt_q;
endmodule

// File: rtl/vt_flags.sv
module vt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vt_prio.sv
module vt_prio
  import vt_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] pend,
  output logic [N-1:0] grant,
  output logic [3:0]   code
);
  always_comb begin
    grant = '0;
    code  = 4'd0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code     = src_code(i);
      end
    end
  end
endmodule

// File: rtl/vec_timer.sv
module vec_timer
  import vt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  logic [CTRL_W-1:0]         ctrl_q;
  logic [NCMP-1:0][CW-1:0]   cmp_q;
  logic [CW-1:0]             count;
  logic                      step;
  logic [NSRC-1:0]           ev;
  logic [NSRC-1:0]           flag_q;
  logic [NSRC-1:0]           ie;
  logic [NSRC-1:0]           grant;
  logic [NSRC-1:0]           clr;
  logic [3:0]                vec_code;
  logic                      wr_hit;
  logic                      vec_rd;
  logic                      load;
  logic                      run;

  assign wr_hit = bus_sel & bus_wr;
  assign vec_rd = bus_sel & ~bus_wr & (bus_addr == A_VEC);
  assign load   = wr_hit & (bus_addr == A_COUNT);
  assign run    = |ctrl_q[CB_RUN_HI:CB_RUN_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_hit && bus_addr == A_CTRL) begin
      ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  for (genvar j = 0; j < NCMP; j++) begin : g_cmpreg
    localparam logic [2:0] MY_ADDR = A_CMP1 + 3'(j);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cmp_q[j] <= '0;
      else if (wr_hit && bus_addr == MY_ADDR) cmp_q[j] <= bus_wdata;
    end
  end

  vt_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tsel      (ctrl_q[CB_TSEL]),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .load      (load),
    .load_val  (bus_wdata),
    .cmp_val   (cmp_q),
    .count     (count),
    .step      (step),
    .ev        (ev)
  );

  assign ie[SRC_CMP1] = ctrl_q[CB_IE_C1];
  assign ie[SRC_CMP2] = ctrl_q[CB_IE_C2];
  assign ie[SRC_OVF]  = ctrl_q[CB_IE_OVF];

  vt_flags #(.N(NSRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev),
    .clr   (clr),
    .flag  (flag_q)
  );

  vt_prio #(.N(NSRC)) u_prio (
    .pend  (flag_q & ie),
    .grant (grant),
    .code  (vec_code)
  );

  assign clr = vec_rd ? grant : '0;
  assign irq = |(flag_q & ie);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = CW'(ctrl_q);
      A_COUNT: bus_rdata = count;
      A_CMP1:  bus_rdata = cmp_q[0];
      A_CMP2:  bus_rdata = cmp_q[1];
      A_VEC:   bus_rdata = CW'(vec_code);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vt_checker.sv
module vt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    ctrl_q,
  input logic [CW-1:0] count,
  input logic          load,
  input logic [CW-1:0] bus_wdata,
  input logic          step,
  input logic [2:0]    ev,
  input logic [2:0]    flag_q,
  input logic [2:0]    grant,
  input logic [3:0]    vec_code,
  input logic          vec_rd,
  input logic          irq
);
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1:0] == 2'b00 && !load) |=> $stable(count));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(bus_wdata)));

  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == {CW{1'b1}}) |=> (count == '0 && flag_q[2]));

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code == 4'd0 || vec_code == 4'd2 || vec_code == 4'd4 || vec_code == 4'd10));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && grant[0] && !ev[0]) |=> !flag_q[0]);

  p_lower_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && grant[0] && flag_q[1]) |=> flag_q[1]);

  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_code != 4'd0));
endmodule

bind vec_timer vt_checker #(.CW(CW)) u_vt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_q    (ctrl_q),
  .count     (count),
  .load      (load),
  .bus_wdata (bus_wdata),
  .step      (step),
  .ev        (ev),
  .flag_q    (flag_q),
  .grant     (grant),
  .vec_code  (vec_code),
  .vec_rd    (vec_rd),
  .irq       (irq)
);

// File: tb/test_vec_timer.sv
module test_vec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  vec_timer i_vec_timer (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input int exp);
    logic [15:0] d;
    rd(a, d);
    check(req, $sformatf("read addr %0d", a), d, exp);
  endtask

  task automatic irq_check(input string req, input bit exp);
    @(negedge clk);
    #1 check(req, "irq", irq, exp);
  endtask

  task automatic ticks(input int n, input bit fast, input bit slow);
    repeat (n) begin
      @(negedge clk);
      tick_fast = fast; tick_slow = slow;
    end
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic t_reset;
    rd_check("R1", 3'd0, 0);
    rd_check("R1", 3'd1, 0);
    rd_check("R1", 3'd2, 0);
    rd_check("R1", 3'd3, 0);
    rd_check("R1", 3'd4, 0);
    irq_check("R1", 1'b0);
  endtask

  task automatic t_stop;
    wr(3'd1, 16'h0100);
    rd_check("R6", 3'd1, 16'h0100);
    wr(3'd0, 16'h0004);
    ticks(5, 1'b1, 1'b1);
    rd_check("R2", 3'd1, 16'h0100);
  endtask

  task automatic t_select;
    wr(3'd0, 16'h0005);
    ticks(7, 1'b1, 1'b0);
    ticks(4, 1'b0, 1'b1);
    rd_check("R3", 3'd1, 16'h0107);
    wr(3'd0, 16'h0001);
    ticks(3, 1'b0, 1'b1);
    ticks(6, 1'b1, 1'b0);
    rd_check("R3", 3'd1, 16'h010A);
  endtask

  task automatic t_load_wins;
    wr(3'd0, 16'h0005);
    @(negedge clk);
    tick_fast = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'h0050;
    @(negedge clk);
    tick_fast = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd_check("R6", 3'd1, 16'h0050);
  endtask

  task automatic t_wrap;
    wr(3'd2, 16'h7000);
    wr(3'd3, 16'h7001);
    wr(3'd0, 16'h000D);
    wr(3'd1, 16'hFFFD);
    ticks(2, 1'b1, 1'b0);
    rd_check("R4", 3'd1, 16'hFFFF);
    rd_check("R7", 3'd4, 0);
    irq_check("R9", 1'b0);
    ticks(1, 1'b1, 1'b0);
    rd_check("R4", 3'd1, 16'h0000);
    irq_check("R9", 1'b1);
    rd_check("R4", 3'd4, 10);
    rd_check("R8", 3'd4, 0);
    irq_check("R9", 1'b0);
  endtask

  task automatic t_compare;
    wr(3'd2, 16'h0020);
    wr(3'd3, 16'h0022);
    wr(3'd0, 16'h0035);
    wr(3'd1, 16'h0020);
    rd_check("R5", 3'd4, 0);
    ticks(1, 1'b1, 1'b0);
    rd_check("R5", 3'd4, 0);
    ticks(1, 1'b1, 1'b0);
    irq_check("R5", 1'b1);
    wr(3'd1, 16'h001F);
    ticks(1, 1'b1, 1'b0);
    rd_check("R7", 3'd4, 2);
    rd_check("R8", 3'd4, 4);
    rd_check("R8", 3'd4, 0);
  endtask

  task automatic t_masked;
    wr(3'd0, 16'h0005);
    wr(3'd2, 16'h0040);
    wr(3'd1, 16'h003F);
    ticks(1, 1'b1, 1'b0);
    irq_check("R10", 1'b0);
    rd_check("R10", 3'd4, 0);
    wr(3'd0, 16'h0015);
    irq_check("R10", 1'b1);
    rd_check("R10", 3'd4, 2);
    rd_check("R8", 3'd4, 0);
  endtask

  task automatic t_all;
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h003D);
    wr(3'd1, 16'hFFFE);
    ticks(1, 1'b1, 1'b0);
    rd_check("R7", 3'd4, 0);
    ticks(1, 1'b1, 1'b0);
    rd_check("R7", 3'd4, 2);
    rd_check("R8", 3'd4, 4);
    rd_check("R8", 3'd4, 10);
    rd_check("R8", 3'd4, 0);
    irq_check("R9", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_stop;
    t_select;
    t_load_wins;
    t_wrap;
    t_compare;
    t_masked;
    t_all;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule